// File: doc/BRIEF.md
# MIDI Note Serial Receiver

This block is a receive-only asynchronous serial port for a musical-instrument control line. It runs from a 4 MHz system clock, and the line carries 31,250 bits per second, so every bit lasts exactly 128 clock cycles. The raw line is first brought into the clock domain through a chain of flip-flops. A falling edge on the idle-high line starts a frame. The start bit is checked again at its midpoint, and any pulse shorter than half a bit is thrown away as noise. The receiver then samples eight data bits, least significant bit first, and a stop bit, each once at its centre. After the stop-bit sample it goes back to waiting for a new falling edge, so it locks onto every byte separately and handles any idle gap between frames, including none at all.

A small tracker follows where each byte sits inside a three-byte message. A byte with its top bit set is a status byte and begins a message. The low seven bits of the second byte, the note number, are latched into a register that drives seven LEDs, and they are held there until the next second byte arrives. Each received byte is also shown on a byte output, together with a one-cycle valid strobe.

Top module: `midi_note_rx`

## Requirements
- R1: After reset, note_led is 0, byte_valid is 0 and the receiver waits in its idle state for a falling edge.
- R2: A frame is one low start bit, eight data bits sent least significant bit first, and one stop bit, each 128 clock cycles long. The decoded byte appears on rx_byte in the same cycle that byte_valid is high.
- R3: byte_valid goes high for exactly one cycle per received frame, right after the stop bit is sampled at its midpoint.
- R4: Frames that follow each other with no idle time are all decoded correctly.
- R5: Frames separated by idle-high gaps of any length are all decoded correctly. Each one is synchronised to its own start edge.
- R6: A low pulse shorter than half a bit time produces no byte_valid, and the receiver returns to idle and decodes the next frame normally.
- R7: A byte with bit 7 = 1 is a status byte and sets the message position to 1. The next data byte (bit 7 = 0) counts as position 2.
- R8: note_led takes bits 6:0 of the byte at position 2 and keeps that value through all other bytes until the next position-2 byte.
- R9: Data bytes without a status byte advance the position 1, 2, 3, and then wrap back to 1.
- R10: The stop bit is not checked. A frame whose stop bit is low still produces byte_valid with its data byte, and no extra frame starts while the line stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| midi_in | input | 1 | Asynchronous serial line, idles high |
| note_led | output | 7 | Note number last held, drives the LEDs |
| byte_valid | output | 1 | One-cycle strobe for each received byte |
| rx_byte | output | 8 | Byte just received, valid while byte_valid is high |

## Verification
Some properties are checked on every cycle by assertions. The strobe must last one cycle and must follow every stop-bit sample. A start bit that is high again at its midpoint must send the receiver back to idle. A status byte must force the position to 1, the position must wrap after the third byte, and the note register must not change unless a second byte is being loaded. Other behaviour can only be shown by the bench's scenarios: that the data bits are decoded in the right order and at the right bit centres, that back-to-back and widely spaced frames both stay in sync, that a short glitch produces no byte at all, and that a low stop bit is accepted without a spurious extra frame.

// File: rtl/midi_rx_pkg.sv
package midi_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  // last counter value of the half-bit wait before the start-bit recheck
  function automatic int half_last(input int clks_per_bit);
    return clks_per_bit / 2 - 1;
  endfunction

  // message position after a byte: status restarts at 1, data advances and wraps
  function automatic int next_pos(input int cur, input bit is_status, input int msg_len);
    if (is_status)           return 1;
    else if (cur >= msg_len) return 1;
    else                     return cur + 1;
  endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b1;
          else     chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b1;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/bit_sampler.sv
module bit_sampler
  import midi_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 128,
  parameter int DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_s,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_out
);
  localparam int CW        = $clog2(CLKS_PER_BIT);
  localparam int IW        = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int HALF_LAST = half_last(CLKS_PER_BIT);
  localparam int BIT_LAST  = CLKS_PER_BIT - 1;

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              prev_q;
  logic              done_q;
  logic [DATA_W-1:0] byte_q;

  // named events
  logic fall_seen, half_hit, bit_hit, stop_sample, last_bit;
  assign fall_seen   = prev_q & ~line_s;
  assign half_hit    = (cnt_q == CW'(HALF_LAST));
  assign bit_hit     = (cnt_q == CW'(BIT_LAST));
  assign last_bit    = (idx_q == IW'(DATA_W - 1));
  assign stop_sample = (state_q == RX_STOP) && bit_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      prev_q  <= 1'b1;
      done_q  <= 1'b0;
      byte_q  <= '0;
    end else begin
      prev_q <= line_s;
      done_q <= 1'b0;
      unique case (state_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (fall_seen) state_q <= RX_START;
        end
        RX_START: begin
          if (half_hit) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            state_q <= line_s ? RX_IDLE : RX_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (bit_hit) begin
            cnt_q   <= '0;
            shift_q <= {line_s, shift_q[DATA_W-1:1]};
            if (last_bit) state_q <= RX_STOP;
            else          idx_q   <= idx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (bit_hit) begin
            cnt_q   <= '0;
            state_q <= RX_IDLE;
            done_q  <= 1'b1;
            byte_q  <= shift_q;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign byte_done = done_q;
  assign byte_out  = byte_q;

  // R3
  byte_done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> !byte_done);
  // R3
  stop_to_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    stop_sample |=> byte_done);
  // R6
  start_glitch_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == RX_START && half_hit && line_s) |=> (state_q == RX_IDLE));
  // R10
  done_back_idle_chk: assert property (@(posedge clk) disable iff (rst)
    byte_done |-> (state_q == RX_IDLE));
endmodule

// File: rtl/msg_tracker.sv
module msg_tracker
  import midi_rx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NOTE_W   = 7,
  parameter int MSG_LEN  = 3,
  parameter int NOTE_POS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_in,
  output logic [NOTE_W-1:0] note
);
  localparam int PW = $clog2(MSG_LEN + 1);

  logic [PW-1:0]     pos_q;
  logic [NOTE_W-1:0] note_q;

  logic          is_status;
  logic [PW-1:0] pos_next;
  logic          note_load;
  assign is_status = byte_in[DATA_W-1];
  assign pos_next  = PW'(next_pos(int'(pos_q), is_status, MSG_LEN));
  assign note_load = byte_done && (pos_next == PW'(NOTE_POS));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      note_q <= '0;
    end else if (byte_done) begin
      pos_q <= pos_next;
      if (note_load) note_q <= byte_in[NOTE_W-1:0];
    end
  end

  assign note = note_q;

  // R7
  status_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_done && byte_in[DATA_W-1]) |=> (pos_q == PW'(1)));
  // R9
  pos_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !byte_in[DATA_W-1] && pos_q == PW'(MSG_LEN)) |=> (pos_q == PW'(1)));
  // R8
  note_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !note_load |=> $stable(note_q));
endmodule

// File: rtl/midi_note_rx.sv
module midi_note_rx #(
  parameter int CLKS_PER_BIT = 128,
  parameter int SYNC_STAGES  = 2,
  parameter int NOTE_W       = 7,
  parameter int MSG_LEN      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              midi_in,
  output logic [NOTE_W-1:0] note_led,
  output logic              byte_valid,
  output logic [7:0]        rx_byte
);
  localparam int DATA_W = 8;

  logic              line_s;
  logic              done;
  logic [DATA_W-1:0] data;

  line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(midi_in), .dout(line_s)
  );

  bit_sampler #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_W(DATA_W)) u_samp (
    .clk(clk), .rst(rst), .line_s(line_s), .byte_done(done), .byte_out(data)
  );

  msg_tracker #(.DATA_W(DATA_W), .NOTE_W(NOTE_W), .MSG_LEN(MSG_LEN), .NOTE_POS(2)) u_trk (
    .clk(clk), .rst(rst), .byte_done(done), .byte_in(data), .note(note_led)
  );

  assign byte_valid = done;
  assign rx_byte    = data;
endmodule

// File: tb/sim_midi_note_rx.sv
`timescale 1ns/1ps
module sim_midi_note_rx;
  localparam int BITC = 128;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       midi_in = 1'b1;
  logic [6:0] note_led;
  logic       byte_valid;
  logic [7:0] rx_byte;

  int checks = 0;
  int errors = 0;
  int strobes = 0;
  int pushed = 0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  midi_note_rx u0 (
    .clk(clk), .rst(rst), .midi_in(midi_in),
    .note_led(note_led), .byte_valid(byte_valid), .rx_byte(rx_byte)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int cycles);
    midi_in = v;
    repeat (cycles) @(posedge clk);
    #1;
  endtask

  // driver: pushes the expected byte, then sends the frame LSB first
  task automatic send_byte(input logic [7:0] b, input logic stop_v, input int gap);
    exp_q.push_back(b);
    pushed++;
    hold_line(1'b0, BITC);
    for (int i = 0; i < 8; i++) hold_line(b[i], BITC);
    hold_line(stop_v, BITC);
    if (gap > 0) hold_line(1'b1, gap);
  endtask

  // monitor: pops and compares on each strobe, checks the one-cycle width
  initial begin
    forever begin
      @(posedge clk); #2;
      if (!rst && byte_valid) begin
        strobes++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected byte", rx_byte, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rx_byte == e, "R2 byte data", rx_byte, e);
        end
        @(posedge clk); #2;
        chk(!byte_valid, "R3 strobe width", byte_valid, 0);
      end
    end
  end

  initial begin
    #(200000 * 10);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s0;
    repeat (4) @(posedge clk); #1;
    rst = 1'b0;
    repeat (3) @(posedge clk); #1;
    // R1 reset state
    chk(note_led == 7'h00, "R1 note after reset", note_led, 0);
    chk(!byte_valid, "R1 strobe after reset", byte_valid, 0);

    // R7 R8: status, note, velocity with short gaps
    send_byte(8'h90, 1'b1, 50);
    send_byte(8'h3C, 1'b1, 50);
    chk(note_led == 7'h3C, "R8 note from second byte", note_led, 7'h3C);
    send_byte(8'h64, 1'b1, 50);
    chk(note_led == 7'h3C, "R8 third byte keeps note", note_led, 7'h3C);

    // R4 back-to-back frames
    send_byte(8'h80, 1'b1, 0);
    send_byte(8'h45, 1'b1, 0);
    send_byte(8'h00, 1'b1, 0);
    chk(note_led == 7'h45, "R4 back-to-back note", note_led, 7'h45);

    // R5 long idle gaps
    hold_line(1'b1, 3000);
    send_byte(8'h90, 1'b1, 2500);
    send_byte(8'h12, 1'b1, 777);
    chk(note_led == 7'h12, "R5 note after long gaps", note_led, 7'h12);
    send_byte(8'h7F, 1'b1, 10);
    chk(note_led == 7'h12, "R8 velocity 7F ignored", note_led, 7'h12);

    // R6 short glitch
    s0 = strobes;
    hold_line(1'b0, 40);
    hold_line(1'b1, 2000);
    chk(strobes == s0, "R6 glitch gives no byte", strobes, s0);
    chk(note_led == 7'h12, "R6 glitch leaves note", note_led, 7'h12);
    send_byte(8'h90, 1'b1, 20);
    send_byte(8'h2A, 1'b1, 20);
    chk(note_led == 7'h2A, "R6 frame after glitch", note_led, 7'h2A);
    send_byte(8'h40, 1'b1, 20);

    // R9 wrap without status: positions 1,2,3,1
    send_byte(8'h11, 1'b1, 20);
    chk(note_led == 7'h2A, "R9 wrapped byte is position 1", note_led, 7'h2A);
    send_byte(8'h22, 1'b1, 20);
    chk(note_led == 7'h22, "R9 position 2 after wrap", note_led, 7'h22);
    send_byte(8'h33, 1'b1, 20);
    send_byte(8'h44, 1'b1, 20);
    chk(note_led == 7'h22, "R9 fourth byte is position 1", note_led, 7'h22);

    // R10 low stop bit still accepted, no extra frame
    send_byte(8'h90, 1'b1, 20);
    send_byte(8'h5B, 1'b0, 0);
    hold_line(1'b1, 400);
    chk(note_led == 7'h5B, "R10 low stop bit accepted", note_led, 7'h5B);

    hold_line(1'b1, 200);
    chk(strobes == pushed, "R3 one strobe per frame", strobes, pushed);
    chk(exp_q.size() == 0, "R2 all bytes received", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule